// File: doc/BRIEF.md
# Banked Memory Mapping Unit

This block widens the 16-bit address of a small processor to a 21-bit physical address. The 64 KB processor space is cut into eight windows of 8 KB. Each window has its own 8-bit page register. The three top address bits pick the page register, and its value takes their place above the 13-bit offset. Page registers are loaded from the accumulator by a transfer command. The command's operand byte is a bit mask, so any set of registers can be loaded in one cycle.

Zero-page cycles are flagged by the processor. They always go to a fixed RAM page, whatever the page register of the lowest window holds. Any other access whose page value is all ones raises a flag, so that the bus fabric can steer it to the hardware-control area. Translation is purely combinational. Only register loads take a clock edge.

Top module: `bank_map_unit`

## Requirements
- R1: Address bits [15:13] select the page register: window n (addresses n*0x2000 to n*0x2000+0x1FFF) uses register n.
- R2: For a non-zero-page access, phys_addr = {page register value, cpu_addr[12:0]}, 21 bits wide, valid in the same cycle as cpu_addr with no clock edge in between.
- R3: When map_load is high at a rising clock edge, each register n with map_mask bit n set (bit 0 = register 0, bit 7 = register 7) takes acc_data, and translation uses the new value from that edge on.
- R4: With several mask bits set, every selected register loads the same acc_data at the same edge.
- R5: A register whose mask bit is clear, or any register while map_load is low, keeps its value. This includes a load with an all-zero mask.
- R6: Reset (rst_n low) clears all eight registers to 0x00, so every window maps to physical page 0x00 and address 0xFFFC maps to 0x01FFC.
- R7: When zp_cycle is high, phys_addr = {0xF8, 5'b0, cpu_addr[7:0]} and io_sel is low, whatever the value of register 0.
- R8: io_sel is high exactly when zp_cycle is low and the selected page value is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for page register loads |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| zp_cycle | input | 1 | Current access is a zero-page access |
| map_load | input | 1 | Page register load strobe |
| map_mask | input | 8 | Bit mask of the registers to load; bit n selects register n |
| acc_data | input | 8 | Accumulator value to load |
| phys_addr | output | 21 | Translated physical address |
| io_sel | output | 1 | Access lands in the hardware-control page |

## Verification
Translation results (phys_addr, io_sel) are due in the same cycle as the address and zp_cycle inputs. The bench drives those inputs on the falling edge and samples one nanosecond later, well before the next rising edge. A register load becomes visible from the rising edge on which map_load is high. The bench raises the strobe on one falling edge, drops it on the next falling edge, updates its own register model, and then samples. Checks of the hold behaviour probe every window after the stimulus and before the next load, so that a register changed by mistake shows up at phys_addr.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
  // Default geometry of the mapper
  localparam int CPU_AW  = 16;
  localparam int PAGE_W  = 8;
  localparam int NWIN    = 8;
  localparam int IDX_W   = $clog2(NWIN);
  localparam int OFF_W   = CPU_AW - IDX_W;
  localparam int PHYS_W  = PAGE_W + OFF_W;
  localparam int ZP_W    = 8;

  localparam logic [PAGE_W-1:0] ZP_PAGE = 8'hF8;
  localparam logic [PAGE_W-1:0] IO_PAGE = 8'hFF;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [PHYS_W-1:0] phys_t;

  // Place a page number above an in-window offset
  function automatic phys_t join_page(input page_t pg, input logic [OFF_W-1:0] off);
    return {pg, off};
  endfunction

  // Zero-page accesses: fixed RAM page, low byte of the address only
  function automatic phys_t zp_target(input logic [ZP_W-1:0] lo);
    return {ZP_PAGE, {(OFF_W-ZP_W){1'b0}}, lo};
  endfunction
endpackage

// File: rtl/bmu_page_regs.sv
module bmu_page_regs #(
  parameter int NREG = bmu_pkg::NWIN,
  parameter int DW   = bmu_pkg::PAGE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [NREG-1:0]          mask,
  input  logic [DW-1:0]            wdata,
  output logic [NREG-1:0][DW-1:0]  pages
);
  // Per-register write enables, brought out for the checks
  logic [NREG-1:0] wr_en;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign wr_en[i] = load & mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pages[i] <= '0;
      else if (wr_en[i]) pages[i] <= wdata;
    end

    // R3/R4: a selected register captures the accumulator value
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (load && mask[i]) |=> pages[i] == $past(wdata));

    // R5: an unselected register holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && mask[i]) |=> $stable(pages[i]));

    // R6: reset clears the register
    assert_reset_R6: assert property (@(posedge clk)
      !rst_n |-> pages[i] == '0);
  end
endmodule

// File: rtl/bmu_window_dec.sv
module bmu_window_dec #(
  parameter int NREG  = bmu_pkg::NWIN,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [IDX_W-1:0] top_bits,
  output logic [IDX_W-1:0] win_idx,
  output logic [NREG-1:0]  win_oh
);
  assign win_idx = top_bits;

  always_comb begin
    win_oh = '0;
    for (int k = 0; k < NREG; k++)
      if (top_bits == IDX_W'(k)) win_oh[k] = 1'b1;
  end

  // R1: exactly one window is active, and it matches the index
  always_comb begin
    assert_one_window_R1: assert ($countones(win_oh) == 1 && win_oh[win_idx]);
  end
endmodule

// File: rtl/bmu_compose.sv
module bmu_compose #(
  parameter int NREG  = bmu_pkg::NWIN,
  parameter int DW    = bmu_pkg::PAGE_W,
  parameter int IDX_W = $clog2(NREG),
  parameter int OFF_W = bmu_pkg::OFF_W
) (
  input  logic [NREG-1:0][DW-1:0] pages,
  input  logic [NREG-1:0]         win_oh,
  input  logic [IDX_W-1:0]        win_idx,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    zp,
  output bmu_pkg::phys_t          phys,
  output logic                    io_hit
);
  import bmu_pkg::*;

  // AND-OR page mux driven by the one-hot window
  logic [DW-1:0] sel_page;
  always_comb begin
    sel_page = '0;
    for (int k = 0; k < NREG; k++)
      sel_page |= pages[k] & {DW{win_oh[k]}};
  end

  logic io_page;
  assign io_page = (sel_page == IO_PAGE);

  always_comb begin
    if (zp) phys = zp_target(offset[ZP_W-1:0]);
    else    phys = join_page(sel_page, offset);
  end
  assign io_hit = io_page & ~zp;

  // R2: translated page comes from the indexed register; offset passes through
  always_comb begin
    if (!zp) begin
      assert_page_R2: assert (phys[PHYS_W-1 -: DW] == pages[win_idx] &&
                              phys[OFF_W-1:0] == offset);
    end
    // R7: zero page never reaches the hardware-control page
    if (zp) begin
      assert_zp_R7: assert (!io_hit && phys[PHYS_W-1 -: DW] == ZP_PAGE);
    end
    // R8: io flag only for the all-ones page
    assert_io_R8: assert (io_hit == (!zp && pages[win_idx] == IO_PAGE));
  end
endmodule

// File: rtl/bank_map_unit.sv
module bank_map_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpu_addr,
  input  logic        zp_cycle,
  input  logic        map_load,
  input  logic [7:0]  map_mask,
  input  logic [7:0]  acc_data,
  output logic [20:0] phys_addr,
  output logic        io_sel
);
  import bmu_pkg::*;

  logic [NWIN-1:0][PAGE_W-1:0] pages;
  logic [IDX_W-1:0]            win_idx;
  logic [NWIN-1:0]             win_oh;
  phys_t                       phys;
  logic                        io_hit;

  bmu_page_regs #(.NREG(NWIN), .DW(PAGE_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (map_load),
    .mask  (map_mask),
    .wdata (acc_data),
    .pages (pages)
  );

  bmu_window_dec #(.NREG(NWIN), .IDX_W(IDX_W)) u_dec (
    .top_bits (cpu_addr[CPU_AW-1 -: IDX_W]),
    .win_idx  (win_idx),
    .win_oh   (win_oh)
  );

  bmu_compose #(.NREG(NWIN), .DW(PAGE_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_cmp (
    .pages   (pages),
    .win_oh  (win_oh),
    .win_idx (win_idx),
    .offset  (cpu_addr[OFF_W-1:0]),
    .zp      (zp_cycle),
    .phys    (phys),
    .io_hit  (io_hit)
  );

  assign phys_addr = phys;
  assign io_sel    = io_hit;

  // R6: while reset is held, every window maps to page 0
  assert_reset_page_R6: assert property (@(posedge clk)
    (!rst_n && !zp_cycle) |-> phys_addr[20:13] == 8'h00);
endmodule

// File: tb/bank_map_unit_test.sv
module bank_map_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic        zp_cycle = 1'b0;
  logic        map_load = 1'b0;
  logic [7:0]  map_mask = 8'h00;
  logic [7:0]  acc_data = 8'h00;
  logic [20:0] phys_addr;
  logic        io_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mdl [8];

  bank_map_unit uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .zp_cycle(zp_cycle),
    .map_load(map_load), .map_mask(map_mask), .acc_data(acc_data),
    .phys_addr(phys_addr), .io_sel(io_sel)
  );

  always #10 clk = ~clk;

  task automatic probe(input logic [15:0] a, input logic zp, input string req);
    logic [20:0] ep;
    logic        eio;
    logic [7:0]  pg;
    @(negedge clk);
    cpu_addr = a;
    zp_cycle = zp;
    #1;
    pg = mdl[a / 16'h2000];
    if (zp) begin
      ep  = 21'(8'hF8) * 21'h2000 + 21'(a & 16'h00FF);
      eio = 1'b0;
    end else begin
      ep  = 21'(pg) * 21'h2000 + 21'(a % 16'h2000);
      eio = (pg == 8'hFF);
    end
    checks++;
    if (phys_addr !== ep || io_sel !== eio) begin
      fails++;
      $display("FAIL %s addr=%h zp=%b: phys=%h io=%b expected phys=%h io=%b",
               req, a, zp, phys_addr, io_sel, ep, eio);
    end
  endtask

  task automatic load(input logic [7:0] msk, input logic [7:0] d, input logic we);
    @(negedge clk);
    map_load = we;
    map_mask = msk;
    acc_data = d;
    @(negedge clk);
    map_load = 1'b0;
    map_mask = 8'h00;
    if (we) for (int i = 0; i < 8; i++) if (msk[i]) mdl[i] = d;
  endtask

  task automatic sweep(input string req);
    for (int w = 0; w < 8; w++) probe(16'(w * 16'h2000 + 16'h0ABC), 1'b0, req);
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    sweep("R6 reset");
    probe(16'hFFFC, 1'b0, "R6 vector");
    probe(16'h0000, 1'b0, "R1 lowest");
  endtask

  task automatic t_startup();
    load(8'h01, 8'hFF, 1'b1);
    load(8'h02, 8'hF8, 1'b1);
    load(8'h80, 8'h3C, 1'b1);
    load(8'h80, 8'h00, 1'b1);
    sweep("R3 single");
    probe(16'h1234, 1'b0, "R8 io page");
    probe(16'h3FFF, 1'b0, "R2 top of window");
    probe(16'h2000, 1'b0, "R1 window edge");
    probe(16'h1FFF, 1'b0, "R1 window edge");
  endtask

  task automatic t_multi();
    load(8'h3C, 8'h55, 1'b1);
    sweep("R4 multi");
    load(8'hC0, 8'hFF, 1'b1);
    probe(16'hC001, 1'b0, "R4 multi io");
    probe(16'hE001, 1'b0, "R4 multi io");
  endtask

  task automatic t_hold();
    load(8'hFF, 8'h99, 1'b0);
    sweep("R5 strobe low");
    load(8'h00, 8'h77, 1'b1);
    sweep("R5 empty mask");
    load(8'h10, 8'h21, 1'b1);
    sweep("R5 neighbours");
  endtask

  task automatic t_zp();
    load(8'h01, 8'hFF, 1'b1);
    probe(16'h0042, 1'b1, "R7 zp io reg");
    probe(16'h00FF, 1'b1, "R7 zp top");
    probe(16'h0042, 1'b0, "R8 same addr non-zp");
    load(8'h01, 8'h07, 1'b1);
    probe(16'h0010, 1'b1, "R7 zp other reg");
    probe(16'h0010, 1'b0, "R2 after reload");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_startup();
    t_multi();
    t_hold();
    t_zp();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule